// File: doc/BRIEF.md
# De-emphasis Mode Selection Controller

This block decides which de-emphasis filter setting a digital audio receive path applies to each sample. It supports four settings, 44.1 kHz, 48 kHz, 32 kHz and 96 kHz, plus OFF. The filters use 50/15 µs time constants. The choice comes from one of two decode tables.

- **Automatic table:** reads the pre-emphasis flag and the 4-bit sampling-frequency code recovered from received channel status.
- **Manual table:** reads three configuration bits held in the block.

A strap input marks a board in pin-configured (parallel) operation. While it is high, the automatic table is always used.

The resolved setting is registered only when a sample strobe arrives, so it never changes in the middle of a sample. It is presented two ways:

- an encoded mode: OFF=0, 44.1 kHz=1, 48 kHz=2, 32 kHz=3, 96 kHz=4;
- a one-hot vector whose bit index equals that code.

A bypass flag is high whenever the mode is OFF. Each strobed audio sample leaves the block one clock later, with the same latency whether it is bypassed or filtered. The filter arithmetic is represented here by an identity stage, so samples come out unchanged in every mode.

Top module: `deemph_mode_sel`

## Requirements
- R1: With the automatic table in use and the pre-emphasis flag high, the frequency codes map to modes as follows; every other code gives mode 0 (OFF).
  - 4'b0000 gives mode 1.
  - 4'b0010 gives mode 2.
  - 4'b0011 gives mode 3.
  - 4'b1010 gives mode 4.
- R2: With the pre-emphasis flag low, the mode is 0 (OFF) whatever the frequency code, the select bit or the manual bits hold.
- R3: With the manual table in use and the pre-emphasis flag high, the value {cfgFreqBit, cfgDemBits[1], cfgDemBits[0]} maps to modes as follows; values 001, 100, 101 and 111 give mode 0.
  - 000 gives mode 1.
  - 010 gives mode 2.
  - 011 gives mode 3.
  - 110 gives mode 4.
- R4: Reset puts the block in a known state.
  - The select bit resets to 1 (automatic table).
  - The manual bits reset to cfgFreqBit=0 and cfgDemBits=2'b01, which decodes to OFF.
  - The outputs show modeCode=0, bypass=1, audioValid=0 and audioOut=0.
- R5: While parallelStrap is high, the automatic table is used even when the select bit is 0.
- R6: bypass is 1 exactly when modeCode is 0. modeOneHot has exactly one bit set, at the index equal to modeCode.
- R7: modeCode and bypass change only on the clock edge where sampleValid is high. Otherwise they hold, whatever the other inputs do.
- R8: A sample presented with sampleValid appears on audioOut one clock later, unchanged, with audioValid high for that single cycle. This holds in both OFF and filtered modes. audioValid is low at all other times.
- R9: The mode, bypass and output sample produced by a strobe reflect the configuration as it stood before that edge. A configuration write on the same edge takes effect from the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| parallelStrap | input | 1 | High forces the automatic table |
| cfgSelWr | input | 1 | Write strobe for the select bit |
| cfgAutoSel | input | 1 | Select bit value: 1 automatic, 0 manual |
| cfgManWr | input | 1 | Write strobe for the manual bits |
| cfgFreqBit | input | 1 | Manual frequency bit (MSB of the manual index) |
| cfgDemBits | input | 2 | Manual mode bits (lower two bits of the manual index) |
| pemFlag | input | 1 | Pre-emphasis flag from channel status |
| fsCode | input | 4 | Sampling-frequency code from channel status |
| sampleValid | input | 1 | Sample strobe |
| audioIn | input | DATA_W | Input audio sample |
| modeCode | output | 3 | Registered encoded mode |
| modeOneHot | output | 5 | Registered one-hot mode, bit index equals modeCode |
| bypass | output | 1 | High when the filter is bypassed (mode OFF) |
| audioOut | output | DATA_W | Output audio sample |
| audioValid | output | 1 | High for one cycle with each output sample |

## Verification
A configuration write and a sample strobe can land on the same clock edge. The question is then which manual setting the strobed sample is tagged with.

The bench programs the manual bits for 48 kHz and then raises the manual write strobe carrying the 96 kHz value in the same cycle as a sample strobe. The scoreboard expects that sample to report mode 2. It expects the following strobe, with no write, to report mode 4.

Between strobes the bench also changes every decode input and requires modeCode to hold. This shows that the new setting waits for a strobe rather than following the configuration.

// File: rtl/demsel_pkg.sv
package demsel_pkg;

  localparam int MODE_W     = 3;
  localparam int MODE_COUNT = 5;

  typedef enum logic [MODE_W-1:0] {
    MODE_OFF  = 3'd0,
    MODE_44K1 = 3'd1,
    MODE_48K  = 3'd2,
    MODE_32K  = 3'd3,
    MODE_96K  = 3'd4
  } demMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic sampleStb;
    logic bypass;
  } pathCtl_t;

  // Automatic table: channel-status frequency code
  function automatic demMode_e autoDecode(input logic [3:0] fs);
    case (fs)
      4'b0000: autoDecode = MODE_44K1;
      4'b0010: autoDecode = MODE_48K;
      4'b0011: autoDecode = MODE_32K;
      4'b1010: autoDecode = MODE_96K;
      default: autoDecode = MODE_OFF;
    endcase
  endfunction

  // Manual table: {frequency bit, mode bits}
  function automatic demMode_e manualDecode(input logic [2:0] sel);
    case (sel)
      3'b000:  manualDecode = MODE_44K1;
      3'b010:  manualDecode = MODE_48K;
      3'b011:  manualDecode = MODE_32K;
      3'b110:  manualDecode = MODE_96K;
      default: manualDecode = MODE_OFF;
    endcase
  endfunction

endpackage

// File: rtl/demsel_ctrl.sv
module demsel_ctrl
  import demsel_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  parallelStrap,
  input  logic                  cfgSelWr,
  input  logic                  cfgAutoSel,
  input  logic                  cfgManWr,
  input  logic                  cfgFreqBit,
  input  logic [1:0]            cfgDemBits,
  input  logic                  pemFlag,
  input  logic [3:0]            fsCode,
  input  logic                  sampleValid,
  output pathCtl_t              pathCtl,
  output logic [MODE_W-1:0]     modeCode,
  output logic [MODE_COUNT-1:0] modeOneHot,
  output logic                  bypass
);

  logic     autoSelQ;
  logic     freqBitQ;
  logic [1:0] demBitsQ;
  demMode_e modeQ;
  demMode_e nextMode;
  logic     useAuto;

  // Configuration bits; R4 reset values
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      autoSelQ <= 1'b1;
      freqBitQ <= 1'b0;
      demBitsQ <= 2'b01;
    end else begin
      if (cfgSelWr) autoSelQ <= cfgAutoSel;
      if (cfgManWr) begin
        freqBitQ <= cfgFreqBit;
        demBitsQ <= cfgDemBits;
      end
    end
  end

  // Table selection and decode (R1, R2, R3, R5)
  always_comb begin
    useAuto = parallelStrap | autoSelQ;
    if (!pemFlag)     nextMode = MODE_OFF;
    else if (useAuto) nextMode = autoDecode(fsCode);
    else              nextMode = manualDecode({freqBitQ, demBitsQ});
  end

  // Mode updates only on a sample strobe (R7)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            modeQ <= MODE_OFF;
    else if (sampleValid) modeQ <= nextMode;
  end

  assign pathCtl.sampleStb = sampleValid;
  assign pathCtl.bypass    = (nextMode == MODE_OFF);

  assign modeCode = modeQ;
  assign bypass   = (modeQ == MODE_OFF);

  for (genvar i = 0; i < MODE_COUNT; i++) begin : g_oneHot
    assign modeOneHot[i] = (modeQ == demMode_e'(i));
  end

endmodule

// File: rtl/demsel_path.sv
module demsel_path
  import demsel_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  pathCtl_t          pathCtl,
  input  logic [DATA_W-1:0] audioIn,
  output logic [DATA_W-1:0] audioOut,
  output logic              audioValid
);

  logic [DATA_W-1:0] audioQ;
  logic [DATA_W-1:0] filtered;
  logic              validQ;

  // Filter stage stand-in: identity, same latency as bypass
  function automatic logic [DATA_W-1:0] filterStage(input logic [DATA_W-1:0] x);
    filterStage = x;
  endfunction

  assign filtered = filterStage(audioIn);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      audioQ <= '0;
      validQ <= 1'b0;
    end else begin
      validQ <= pathCtl.sampleStb;
      if (pathCtl.sampleStb)
        audioQ <= pathCtl.bypass ? audioIn : filtered;
    end
  end

  assign audioOut   = audioQ;
  assign audioValid = validQ;

endmodule

// File: rtl/deemph_mode_sel.sv
module deemph_mode_sel
  import demsel_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  parallelStrap,
  input  logic                  cfgSelWr,
  input  logic                  cfgAutoSel,
  input  logic                  cfgManWr,
  input  logic                  cfgFreqBit,
  input  logic [1:0]            cfgDemBits,
  input  logic                  pemFlag,
  input  logic [3:0]            fsCode,
  input  logic                  sampleValid,
  input  logic [DATA_W-1:0]     audioIn,
  output logic [MODE_W-1:0]     modeCode,
  output logic [MODE_COUNT-1:0] modeOneHot,
  output logic                  bypass,
  output logic [DATA_W-1:0]     audioOut,
  output logic                  audioValid
);

  pathCtl_t pathCtl;

  demsel_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .parallelStrap(parallelStrap),
    .cfgSelWr(cfgSelWr), .cfgAutoSel(cfgAutoSel),
    .cfgManWr(cfgManWr), .cfgFreqBit(cfgFreqBit), .cfgDemBits(cfgDemBits),
    .pemFlag(pemFlag), .fsCode(fsCode), .sampleValid(sampleValid),
    .pathCtl(pathCtl), .modeCode(modeCode), .modeOneHot(modeOneHot),
    .bypass(bypass)
  );

  demsel_path #(.DATA_W(DATA_W)) u_path (
    .clk(clk), .rstN(rstN), .pathCtl(pathCtl), .audioIn(audioIn),
    .audioOut(audioOut), .audioValid(audioValid)
  );

endmodule

// File: rtl/deemph_mode_sel_chk.sv
module deemph_mode_sel_chk #(
  parameter int DATA_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              parallelStrap,
  input logic              pemFlag,
  input logic [3:0]        fsCode,
  input logic              sampleValid,
  input logic [DATA_W-1:0] audioIn,
  input logic [2:0]        modeCode,
  input logic [4:0]        modeOneHot,
  input logic              bypass,
  input logic [DATA_W-1:0] audioOut,
  input logic              audioValid
);

  p_auto96_r1: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && pemFlag && parallelStrap && fsCode == 4'b1010) |=> (modeCode == 3'd4));

  p_auto_other_r1: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && pemFlag && parallelStrap && fsCode == 4'b0001) |=> (modeCode == 3'd0));

  p_pem_off_r2: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && !pemFlag) |=> (modeCode == 3'd0 && bypass));

  p_strap_auto_r5: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && pemFlag && parallelStrap && fsCode == 4'b0010) |=> (modeCode == 3'd2));

  p_onehot_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(modeOneHot) == 1) && (modeOneHot[0] == bypass));

  p_mode_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> ($stable(modeCode) && $stable(bypass)));

  p_latency_r8: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> (audioValid && audioOut == $past(audioIn)));

  p_no_valid_r8: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> !audioValid);

endmodule

bind deemph_mode_sel deemph_mode_sel_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .parallelStrap(parallelStrap), .pemFlag(pemFlag),
  .fsCode(fsCode), .sampleValid(sampleValid), .audioIn(audioIn),
  .modeCode(modeCode), .modeOneHot(modeOneHot), .bypass(bypass),
  .audioOut(audioOut), .audioValid(audioValid)
);

// File: tb/deemph_mode_sel_bench.sv
`timescale 1ns/1ps
module deemph_mode_sel_bench;

  localparam int DATA_W = 24;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              parallelStrap = 1'b0;
  logic              cfgSelWr = 1'b0;
  logic              cfgAutoSel = 1'b0;
  logic              cfgManWr = 1'b0;
  logic              cfgFreqBit = 1'b0;
  logic [1:0]        cfgDemBits = 2'b00;
  logic              pemFlag = 1'b0;
  logic [3:0]        fsCode = 4'b0000;
  logic              sampleValid = 1'b0;
  logic [DATA_W-1:0] audioIn = '0;
  logic [2:0]        modeCode;
  logic [4:0]        modeOneHot;
  logic              bypass;
  logic [DATA_W-1:0] audioOut;
  logic              audioValid;

  int errors = 0;
  int checks = 0;
  int dataCnt = 0;
  bit finished = 1'b0;

  // Bench model of configuration state
  bit       refAuto = 1'b1;
  bit [2:0] refMan  = 3'b001;

  int                expCode[$];
  logic [DATA_W-1:0] expData[$];
  string             expTag[$];

  always #10 clk = ~clk;

  deemph_mode_sel #(.DATA_W(DATA_W)) u_deemph_mode_sel (
    .clk(clk), .rstN(rstN), .parallelStrap(parallelStrap),
    .cfgSelWr(cfgSelWr), .cfgAutoSel(cfgAutoSel), .cfgManWr(cfgManWr),
    .cfgFreqBit(cfgFreqBit), .cfgDemBits(cfgDemBits), .pemFlag(pemFlag),
    .fsCode(fsCode), .sampleValid(sampleValid), .audioIn(audioIn),
    .modeCode(modeCode), .modeOneHot(modeOneHot), .bypass(bypass),
    .audioOut(audioOut), .audioValid(audioValid)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference from the requirement tables
  function automatic int refMode(input bit pem, input bit strap, input bit [3:0] fs);
    if (!pem) return 0;                       // R2
    if (strap || refAuto) begin               // R1, R5
      if (fs == 4'b0000) return 1;
      if (fs == 4'b0010) return 2;
      if (fs == 4'b0011) return 3;
      if (fs == 4'b1010) return 4;
      return 0;
    end
    if (refMan == 3'b000) return 1;           // R3
    if (refMan == 3'b010) return 2;
    if (refMan == 3'b011) return 3;
    if (refMan == 3'b110) return 4;
    return 0;
  endfunction

  task automatic writeSel(input bit autoVal);
    @(negedge clk);
    cfgSelWr = 1'b1; cfgAutoSel = autoVal;
    @(negedge clk);
    cfgSelWr = 1'b0;
    refAuto = autoVal;
  endtask

  task automatic writeMan(input bit [2:0] val);
    @(negedge clk);
    cfgManWr = 1'b1; cfgFreqBit = val[2]; cfgDemBits = val[1:0];
    @(negedge clk);
    cfgManWr = 1'b0;
    refMan = val;
  endtask

  // Driver: one strobe, pushes expected item; optional manual write on same edge
  task automatic drive(input bit pem, input bit strap, input bit [3:0] fs, input string tag,
                       input bit wrMan = 1'b0, input bit [2:0] manVal = 3'b000);
    logic [DATA_W-1:0] d;
    @(negedge clk);
    dataCnt++;
    d = DATA_W'(32'h5A0000 ^ (dataCnt * 32'h01F3));
    pemFlag = pem; parallelStrap = strap; fsCode = fs;
    audioIn = d; sampleValid = 1'b1;
    expCode.push_back(refMode(pem, strap, fs));
    expData.push_back(d);
    expTag.push_back(tag);
    if (wrMan) begin
      cfgManWr = 1'b1; cfgFreqBit = manVal[2]; cfgDemBits = manVal[1:0];
    end
    @(negedge clk);
    sampleValid = 1'b0; cfgManWr = 1'b0;
    if (wrMan) refMan = manVal;             // R9: applies from the next strobe
  endtask

  // Monitor: pops and compares each produced sample
  always @(negedge clk) begin
    if (rstN && audioValid) begin
      if (expCode.size() == 0) begin
        check("R8 unexpected audioValid", 32'd1, 32'd0);
      end else begin
        int c;
        logic [DATA_W-1:0] d;
        string t;
        c = expCode.pop_front(); d = expData.pop_front(); t = expTag.pop_front();
        check({t, " modeCode"}, 32'(modeCode), 32'(c));
        check("R6 oneHot", 32'(modeOneHot), 32'(5'b00001 << c));
        check("R6 bypass", 32'(bypass), 32'(c == 0));
        check("R8 audioOut", 32'(audioOut), 32'(d));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R4 reset state
    check("R4 modeCode", 32'(modeCode), 32'd0);
    check("R4 bypass", 32'(bypass), 32'd1);
    check("R4 audioValid", 32'(audioValid), 32'd0);
    check("R4 audioOut", 32'(audioOut), 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R4: automatic is the default
    drive(1'b1, 1'b0, 4'b0000, "R4 default auto");

    // R1/R2: full automatic sweep
    for (int p = 0; p < 2; p++)
      for (int f = 0; f < 16; f++)
        drive(p[0], 1'b0, f[3:0], p[0] ? "R1 auto sweep" : "R2 pem clear");

    // R4: manual reset value decodes to OFF
    writeSel(1'b0);
    drive(1'b1, 1'b0, 4'b0000, "R4 manual reset OFF");

    // R3/R2: full manual sweep
    for (int m = 0; m < 8; m++) begin
      writeMan(m[2:0]);
      drive(1'b1, 1'b0, 4'b1111, "R3 manual sweep");
      drive(1'b0, 1'b0, 4'b0010, "R2 pem clear manual");
    end

    // R5: strap forces automatic while select is manual
    writeMan(3'b001);
    drive(1'b1, 1'b1, 4'b0011, "R5 strap auto 32k");
    drive(1'b1, 1'b1, 4'b1010, "R5 strap auto 96k");
    drive(1'b1, 1'b1, 4'b0111, "R5 strap auto OFF");

    // R7: hold without strobe
    drive(1'b1, 1'b1, 4'b1010, "R7 setup");
    @(negedge clk);
    pemFlag = 1'b0; fsCode = 4'b0000; parallelStrap = 1'b0;
    writeMan(3'b000);
    writeSel(1'b1);
    repeat (2) @(negedge clk);
    check("R7 hold modeCode", 32'(modeCode), 32'd4);
    check("R7 hold bypass", 32'(bypass), 32'd0);
    check("R8 no valid between strobes", 32'(audioValid), 32'd0);

    // R9: manual write on the same edge as a strobe
    writeSel(1'b0);
    writeMan(3'b010);
    drive(1'b1, 1'b0, 4'b0000, "R9 old config used", 1'b1, 3'b110);
    drive(1'b1, 1'b0, 4'b0000, "R9 new config next");

    // R8: back-to-back strobes
    writeSel(1'b1);
    @(negedge clk);
    sampleValid = 1'b1; pemFlag = 1'b1; parallelStrap = 1'b0;
    for (int k = 0; k < 4; k++) begin
      logic [DATA_W-1:0] d;
      dataCnt++;
      d = DATA_W'(dataCnt * 32'h3C1);
      fsCode = (k % 2 == 0) ? 4'b0010 : 4'b0101;
      audioIn = d;
      expCode.push_back(refMode(1'b1, 1'b0, fsCode));
      expData.push_back(d);
      expTag.push_back("R8 back-to-back");
      @(negedge clk);
    end
    sampleValid = 1'b0;

    repeat (4) @(negedge clk);
    check("R8 all samples produced", 32'(expCode.size()), 32'd0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule